// File: doc/BRIEF.md
# JTAG Debug Data Register Bank

This block holds the data-register side of a JTAG debug port. An external TAP controller supplies decoded state strobes (Test-Logic-Reset, Capture-DR, Shift-DR, Update-DR) and the current instruction code. The block selects one of three serial paths between `tdi_i` and `tdo_o`. The first is a transmit scan register whose active length comes from a message-length field. The second is a scan register over an abort-mask register. The third is a 1-bit bypass register.

On the local-bus side there is a small transmit semaphore. The bus posts a message by writing a location value, and that write raises the transmit interrupt. When the debugger finishes a transmit scan with Update-DR, the location field is set to all ones and the interrupt is dropped, so the link can take a new transaction. A separate instruction pulses a debugger reset during Update-DR.

The block runs entirely on TCK. Capture and shift act on the rising edge. Parallel outputs and TDO change on the falling edge. Bus-side strobes are assumed to be already synchronous to TCK.

Top module: `dbg_dr_bank`

## Requirements
- R1: With instruction code 4'h3 (transmit scan), the rising edge that ends a Capture-DR cycle loads `tx_buf_i` into the transmit shift register. In each following Shift-DR cycle, `tdo_o` presents the next bit, least significant first, after the falling edge, without inversion.
- R2: The transmit path length L equals `msg_len_i` when it lies in 1..DATA_W, and equals DATA_W for 0 or any larger value. A bit shifted in from `tdi_i` reaches `tdo_o` L Shift-DR cycles later.
- R3: At the falling edge inside Update-DR under 4'h3, `tx_loc_o` becomes all ones and `tx_irq_o` goes low. An Update-DR under any other code leaves both unchanged, and there is no parallel write back into the transmit buffer.
- R4: `tx_post_i` high at a falling edge loads `tx_loc_wdata_i` into `tx_loc_o` and raises `tx_irq_o`. If a transmit-scan release falls on the same edge, the release wins.
- R5: With code 4'h5 (abort mask), Capture-DR loads `abort_mask_o` into a MASK_W-bit shift path, and Update-DR writes the shifted value to `abort_mask_o` at the falling edge. Without that Update-DR, `abort_mask_o` holds its value.
- R6: With code 4'h7 (debugger reset), `dbg_rst_o` is high from the falling edge inside Update-DR to the next falling edge, and the serial path is the bypass bit.
- R7: Every code other than 4'h3, 4'h5 and 4'h7 selects the bypass bit. Capture-DR clears it, each Shift-DR cycle delays `tdi_i` by one stage, and Update-DR has no effect on `dbg_rst_o` or `abort_mask_o`.
- R8: A Test-Logic-Reset cycle clears `abort_mask_o` and `dbg_rst_o` at its falling edge, overriding any update, and clears the bypass bit at its closing rising edge.
- R9: While `rst_ni` is low, `tdo_o`, `abort_mask_o`, `dbg_rst_o` and `tx_irq_o` are 0, and `tx_loc_o` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tlr_i | input | 1 | TAP is in Test-Logic-Reset |
| capture_dr_i | input | 1 | TAP is in Capture-DR |
| shift_dr_i | input | 1 | TAP is in Shift-DR |
| update_dr_i | input | 1 | TAP is in Update-DR |
| ir_i | input | 4 | Current instruction code |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out, changes on falling TCK |
| tx_buf_i | input | DATA_W | Transmit data buffer |
| msg_len_i | input | $clog2(DATA_W+1) | Message length field |
| tx_post_i | input | 1 | Bus posts a transmit message |
| tx_loc_wdata_i | input | LOC_W | Location value written on post |
| tx_loc_o | output | LOC_W | Transmit location / semaphore field |
| tx_irq_o | output | 1 | Transmit interrupt |
| abort_mask_o | output | MASK_W | Abort mask register |
| dbg_rst_o | output | 1 | Debugger reset pulse |

## Verification
A shift register left at the wrong length or insertion point shows up at `tdo_o` at once. Captured data is then misordered within the first L Shift-DR cycles, and bits shifted in come back early or late at exactly cycle L. A wrong mask or semaphore value is visible on `abort_mask_o` or `tx_loc_o` and `tx_irq_o` right after the falling edge of the Update-DR cycle. A wrong mask also returns through TDO on the next abort-mask capture. A stuck bypass stage or a reset pulse that is too long is visible within one TCK cycle of the offending state.

// File: rtl/dbg_dr_pkg.sv
`timescale 1ns/1ps
package dbg_dr_pkg;
  localparam int unsigned IR_W = 4;
  typedef logic [IR_W-1:0] ir_t;

  localparam ir_t IR_SCAN_TX    = 4'h3;
  localparam ir_t IR_ABORT_MASK = 4'h5;
  localparam ir_t IR_DBG_RST    = 4'h7;

  typedef enum logic [1:0] {
    SEL_BYP  = 2'd0,
    SEL_TX   = 2'd1,
    SEL_MASK = 2'd2
  } dr_sel_e;
endpackage

// File: rtl/dbg_shift_reg.sv
`timescale 1ns/1ps
// Capture/shift register with a run-time length; tdi enters at bit len-1.
module dbg_shift_reg #(
  parameter int unsigned W  = 8,
  localparam int unsigned LW = $clog2(W + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          cap_i,
  input  logic          shift_i,
  input  logic [W-1:0]  cap_data_i,
  input  logic [LW-1:0] len_i,
  input  logic          tdi_i,
  output logic [W-1:0]  q_o
);
  logic [W-1:0] nxt;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic upper;
    if (i == W - 1) begin : g_top
      assign upper = 1'b0;
    end else begin : g_mid
      assign upper = q_o[i+1];
    end
    assign nxt[i] = (len_i == LW'(i + 1)) ? tdi_i :
                    (len_i >  LW'(i + 1)) ? upper : 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (clr_i)   q_o <= '0;
    else if (cap_i)   q_o <= cap_data_i;
    else if (shift_i) q_o <= nxt;
  end
endmodule

// File: rtl/dbg_tx_sem.sv
`timescale 1ns/1ps
// Transmit semaphore; falling-edge update stage.
module dbg_tx_sem #(
  parameter int unsigned LOC_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             release_i,
  input  logic             post_i,
  input  logic [LOC_W-1:0] loc_wdata_i,
  output logic [LOC_W-1:0] loc_o,
  output logic             irq_o
);
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      loc_o <= '1;
      irq_o <= 1'b0;
    end else if (release_i) begin
      loc_o <= '1;
      irq_o <= 1'b0;
    end else if (post_i) begin
      loc_o <= loc_wdata_i;
      irq_o <= 1'b1;
    end
  end
endmodule

// File: rtl/dbg_dr_bank.sv
`timescale 1ns/1ps
module dbg_dr_bank
  import dbg_dr_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned MASK_W = 8,
  parameter int unsigned LOC_W  = 4,
  localparam int unsigned LEN_W   = $clog2(DATA_W + 1),
  localparam int unsigned MASK_LW = $clog2(MASK_W + 1)
) (
  input  logic              tck_i,
  input  logic              rst_ni,
  input  logic              tlr_i,
  input  logic              capture_dr_i,
  input  logic              shift_dr_i,
  input  logic              update_dr_i,
  input  logic [IR_W-1:0]   ir_i,
  input  logic              tdi_i,
  output logic              tdo_o,
  input  logic [DATA_W-1:0] tx_buf_i,
  input  logic [LEN_W-1:0]  msg_len_i,
  input  logic              tx_post_i,
  input  logic [LOC_W-1:0]  tx_loc_wdata_i,
  output logic [LOC_W-1:0]  tx_loc_o,
  output logic              tx_irq_o,
  output logic [MASK_W-1:0] abort_mask_o,
  output logic              dbg_rst_o
);
  dr_sel_e           sel;
  logic [LEN_W-1:0]  tx_len;
  logic [DATA_W-1:0] tx_q;
  logic [MASK_W-1:0] mask_sr_q;
  logic [0:0]        byp_q;
  logic              unused_tx_hi;

  always_comb begin
    case (ir_i)
      IR_SCAN_TX:    sel = SEL_TX;
      IR_ABORT_MASK: sel = SEL_MASK;
      default:       sel = SEL_BYP;
    endcase
  end

  // Out-of-range length falls back to the full register.
  assign tx_len = (msg_len_i == '0 || msg_len_i > LEN_W'(DATA_W)) ?
                  LEN_W'(DATA_W) : msg_len_i;

  dbg_shift_reg #(.W(DATA_W)) u_tx_sr (
    .clk_i      (tck_i),
    .rst_ni     (rst_ni),
    .clr_i      (1'b0),
    .cap_i      (capture_dr_i && sel == SEL_TX),
    .shift_i    (shift_dr_i && sel == SEL_TX),
    .cap_data_i (tx_buf_i),
    .len_i      (tx_len),
    .tdi_i      (tdi_i),
    .q_o        (tx_q)
  );

  dbg_shift_reg #(.W(MASK_W)) u_mask_sr (
    .clk_i      (tck_i),
    .rst_ni     (rst_ni),
    .clr_i      (1'b0),
    .cap_i      (capture_dr_i && sel == SEL_MASK),
    .shift_i    (shift_dr_i && sel == SEL_MASK),
    .cap_data_i (abort_mask_o),
    .len_i      (MASK_LW'(MASK_W)),
    .tdi_i      (tdi_i),
    .q_o        (mask_sr_q)
  );

  dbg_shift_reg #(.W(1)) u_byp_sr (
    .clk_i      (tck_i),
    .rst_ni     (rst_ni),
    .clr_i      (tlr_i),
    .cap_i      (capture_dr_i && sel == SEL_BYP),
    .shift_i    (shift_dr_i && sel == SEL_BYP),
    .cap_data_i (1'b0),
    .len_i      (1'b1),
    .tdi_i      (tdi_i),
    .q_o        (byp_q)
  );

  assign unused_tx_hi = ^tx_q[DATA_W-1:1];

  dbg_tx_sem #(.LOC_W(LOC_W)) u_tx_sem (
    .clk_i       (tck_i),
    .rst_ni      (rst_ni),
    .release_i   (update_dr_i && ir_i == IR_SCAN_TX),
    .post_i      (tx_post_i),
    .loc_wdata_i (tx_loc_wdata_i),
    .loc_o       (tx_loc_o),
    .irq_o       (tx_irq_o)
  );

  // Falling-edge stage: TDO and parallel outputs.
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdo_o        <= 1'b0;
      abort_mask_o <= '0;
      dbg_rst_o    <= 1'b0;
    end else begin
      case (sel)
        SEL_TX:   tdo_o <= tx_q[0];
        SEL_MASK: tdo_o <= mask_sr_q[0];
        default:  tdo_o <= byp_q[0];
      endcase
      if (tlr_i)
        abort_mask_o <= '0;
      else if (update_dr_i && ir_i == IR_ABORT_MASK)
        abort_mask_o <= mask_sr_q;
      dbg_rst_o <= !tlr_i && update_dr_i && ir_i == IR_DBG_RST;
    end
  end
endmodule

// File: rtl/dbg_dr_bank_chk.sv
`timescale 1ns/1ps
module dbg_dr_bank_chk
  import dbg_dr_pkg::*;
#(
  parameter int unsigned MASK_W = 8,
  parameter int unsigned LOC_W  = 4
) (
  input logic              tck_i,
  input logic              rst_ni,
  input logic              tlr_i,
  input logic              update_dr_i,
  input logic [IR_W-1:0]   ir_i,
  input logic              tx_post_i,
  input logic [LOC_W-1:0]  tx_loc_wdata_i,
  input logic [LOC_W-1:0]  tx_loc_o,
  input logic              tx_irq_o,
  input logic [MASK_W-1:0] abort_mask_o,
  input logic              dbg_rst_o
);
  a_r3_release: assert property (@(negedge tck_i) disable iff (!rst_ni)
    (update_dr_i && ir_i == IR_SCAN_TX) |=> (tx_loc_o == '1 && !tx_irq_o));

  a_r3_sem_hold: assert property (@(negedge tck_i) disable iff (!rst_ni)
    (!tx_post_i && !(update_dr_i && ir_i == IR_SCAN_TX))
      |=> ($stable(tx_loc_o) && $stable(tx_irq_o)));

  a_r4_post: assert property (@(negedge tck_i) disable iff (!rst_ni)
    (tx_post_i && !(update_dr_i && ir_i == IR_SCAN_TX))
      |=> (tx_irq_o && tx_loc_o == $past(tx_loc_wdata_i)));

  a_r5_mask_hold: assert property (@(negedge tck_i) disable iff (!rst_ni)
    (!tlr_i && !(update_dr_i && ir_i == IR_ABORT_MASK)) |=> $stable(abort_mask_o));

  a_r6_rst_on: assert property (@(negedge tck_i) disable iff (!rst_ni)
    (!tlr_i && update_dr_i && ir_i == IR_DBG_RST) |=> dbg_rst_o);

  a_r6_rst_off: assert property (@(negedge tck_i) disable iff (!rst_ni)
    !(update_dr_i && ir_i == IR_DBG_RST) |=> !dbg_rst_o);

  a_r8_tlr_clear: assert property (@(negedge tck_i) disable iff (!rst_ni)
    tlr_i |=> (abort_mask_o == '0 && !dbg_rst_o));
endmodule

bind dbg_dr_bank dbg_dr_bank_chk #(.MASK_W(MASK_W), .LOC_W(LOC_W)) u_chk (
  .tck_i          (tck_i),
  .rst_ni         (rst_ni),
  .tlr_i          (tlr_i),
  .update_dr_i    (update_dr_i),
  .ir_i           (ir_i),
  .tx_post_i      (tx_post_i),
  .tx_loc_wdata_i (tx_loc_wdata_i),
  .tx_loc_o       (tx_loc_o),
  .tx_irq_o       (tx_irq_o),
  .abort_mask_o   (abort_mask_o),
  .dbg_rst_o      (dbg_rst_o)
);

// File: tb/dbg_dr_bank_bench.sv
`timescale 1ns/1ps
module dbg_dr_bank_bench;
  localparam int DW = 8;
  localparam int MW = 4;
  localparam int LW = 4;
  localparam int LENW = $clog2(DW + 1);

  logic tck = 1'b0;
  logic rst_n = 1'b0;
  logic tlr = 0, cap = 0, sh = 0, upd = 0, tdi = 0, post = 0;
  logic [3:0]      ir = 4'hF;
  logic [DW-1:0]   tx_data = '0;
  logic [LENW-1:0] msg_len = '0;
  logic [LW-1:0]   wdata = '0;
  logic            tdo, irq, dbg_rst;
  logic [LW-1:0]   loc;
  logic [MW-1:0]   mask;

  int n_chk = 0;
  int n_err = 0;

  always #5 tck = ~tck;

  dbg_dr_bank #(.DATA_W(DW), .MASK_W(MW), .LOC_W(LW)) u_dbg_dr_bank (
    .tck_i          (tck),
    .rst_ni         (rst_n),
    .tlr_i          (tlr),
    .capture_dr_i   (cap),
    .shift_dr_i     (sh),
    .update_dr_i    (upd),
    .ir_i           (ir),
    .tdi_i          (tdi),
    .tdo_o          (tdo),
    .tx_buf_i       (tx_data),
    .msg_len_i      (msg_len),
    .tx_post_i      (post),
    .tx_loc_wdata_i (wdata),
    .tx_loc_o       (loc),
    .tx_irq_o       (irq),
    .abort_mask_o   (mask),
    .dbg_rst_o      (dbg_rst)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One TAP cycle: drive after rising edge, return just after the falling edge.
  task automatic cyc(input logic c, input logic s, input logic u,
                     input logic t, input logic ti, input logic p);
    @(posedge tck); #2;
    cap = c; sh = s; upd = u; tlr = t; tdi = ti; post = p;
    @(negedge tck); #2;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  task automatic scan_tx(input logic [DW-1:0] d, input int mlen, input int leff);
    logic [DW-1:0] pat;
    logic [LW-1:0] wv;
    pat = d ^ 8'hA5;
    wv = d[LW-1:0] ^ LW'(mlen);
    ir = 4'h3; msg_len = LENW'(mlen); tx_data = d; wdata = wv;
    cyc(0, 0, 0, 0, 0, 1);
    chk("R4", "post irq", 32'(irq), 32'd1);
    chk("R4", "post loc", 32'(loc), 32'(wv));
    cyc(1, 0, 0, 0, 0, 0);
    for (int j = 0; j < 2 * leff; j++) begin
      cyc(0, 1, 0, 0, (j < leff) ? pat[j] : 1'b0, 0);
      if (j < leff) chk("R1", "tx data bit", 32'(tdo), 32'(d[j]));
      else          chk("R2", "tdi after L shifts", 32'(tdo), 32'(pat[j-leff]));
    end
    cyc(0, 0, 1, 0, 0, 0);
    chk("R3", "release loc", 32'(loc), 32'((1 << LW) - 1));
    chk("R3", "release irq", 32'(irq), 32'd0);
  endtask

  task automatic scan_byp(input logic [3:0] code, input logic [3:0] pat, input string req);
    ir = code;
    cyc(1, 0, 0, 0, 0, 0);
    for (int j = 0; j < 4; j++) begin
      cyc(0, 1, 0, 0, pat[j], 0);
      chk(req, "bypass tdo", 32'(tdo), (j == 0) ? 32'd0 : 32'(pat[j-1]));
    end
  endtask

  initial begin
    #1_500_000;
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [MW-1:0] prev;
    #23;
    chk("R9", "reset tdo", 32'(tdo), 32'd0);
    chk("R9", "reset mask", 32'(mask), 32'd0);
    chk("R9", "reset dbg_rst", 32'(dbg_rst), 32'd0);
    chk("R9", "reset irq", 32'(irq), 32'd0);
    chk("R9", "reset loc", 32'(loc), 32'((1 << LW) - 1));
    rst_n = 1'b1;

    // R1/R2/R3/R4: every data value at every legal length
    for (int l = 1; l <= DW; l++)
      for (int d = 0; d < 256; d++)
        scan_tx(DW'(d), l, l);
    // R2: zero and oversize lengths select the full register
    scan_tx(8'h5C, 0, DW);
    scan_tx(8'h93, 9, DW);
    scan_tx(8'h2E, 15, DW);

    // R4: post and release on the same edge, release wins
    ir = 4'h3; wdata = 4'h6;
    cyc(0, 0, 1, 0, 0, 1);
    chk("R4", "collision loc", 32'(loc), 32'hF);
    chk("R4", "collision irq", 32'(irq), 32'd0);

    // R5: full sweep of mask values, readback through TDO
    wdata = 4'h9;
    cyc(0, 0, 0, 0, 0, 1);
    ir = 4'h5; prev = '0;
    for (int v = 0; v < (1 << MW); v++) begin
      cyc(1, 0, 0, 0, 0, 0);
      for (int j = 0; j < MW; j++) begin
        cyc(0, 1, 0, 0, 1'(v >> j), 0);
        chk("R5", "mask readback", 32'(tdo), 32'(prev[j]));
      end
      cyc(0, 0, 1, 0, 0, 0);
      chk("R5", "mask update", 32'(mask), 32'(v));
      chk("R3", "mask update keeps irq", 32'(irq), 32'd1);
      chk("R3", "mask update keeps loc", 32'(loc), 32'h9);
      prev = MW'(v);
    end
    // R5: shift without update leaves mask alone
    cyc(1, 0, 0, 0, 0, 0);
    for (int j = 0; j < MW; j++) cyc(0, 1, 0, 0, ~prev[j], 0);
    cyc(0, 0, 0, 0, 0, 0);
    chk("R5", "no update hold", 32'(mask), 32'(prev));

    // R6: debugger reset pulse and bypass path
    scan_byp(4'h7, 4'b1011, "R6");
    cyc(0, 0, 1, 0, 0, 0);
    chk("R6", "dbg_rst during update", 32'(dbg_rst), 32'd1);
    chk("R6", "mask untouched", 32'(mask), 32'(prev));
    cyc(0, 0, 0, 0, 0, 0);
    chk("R6", "dbg_rst released", 32'(dbg_rst), 32'd0);

    // R7: unsupported codes use bypass, update has no side effect
    foreach (ir[i]) begin end
    for (int k = 0; k < 16; k++) begin
      if (k == 3 || k == 5 || k == 7) continue;
      scan_byp(4'(k), 4'(k) ^ 4'b0110, "R7");
      cyc(0, 0, 1, 0, 0, 0);
      chk("R7", "no dbg_rst", 32'(dbg_rst), 32'd0);
      chk("R7", "mask unchanged", 32'(mask), 32'(prev));
      cyc(0, 0, 0, 0, 0, 0);
    end

    // R8: TLR clears mask and bypass, overrides reset update
    ir = 4'hF;
    cyc(0, 1, 0, 0, 1, 0);
    cyc(0, 0, 0, 1, 0, 0);
    chk("R8", "mask cleared", 32'(mask), 32'd0);
    chk("R8", "bypass still set", 32'(tdo), 32'd1);
    cyc(0, 0, 0, 0, 0, 0);
    chk("R8", "bypass cleared", 32'(tdo), 32'd0);
    ir = 4'h7;
    cyc(0, 0, 1, 1, 0, 0);
    chk("R8", "tlr blocks dbg_rst", 32'(dbg_rst), 32'd0);
    cyc(0, 0, 0, 0, 0, 0);

    summary();
    $finish;
  end
endmodule